// File: doc/BRIEF.md
# APB Completer to AHB-Lite Manager Bridge

This block lets a simple peripheral-bus master reach an AHB-Lite subsystem. It behaves as an APB3/APB4 completer on one side and as an AHB-Lite manager on the other, and both sides share one clock. Each APB transfer becomes exactly one AHB single transfer. During the APB setup cycle the request is registered. The AHB address phase is launched in the next cycle, and the APB access phase is held with wait states until the AHB data phase finishes.

AHB attributes that have no APB counterpart are fixed: single bursts and no locking. In APB4 mode the transfer size, the low address bits and the protection code are derived from the byte strobes and the protection input. A build-time option places a register stage on the returned read data, ready and error. This option costs one extra wait cycle and removes the combinational path from the AHB responder to the APB master.

Top module: `apb_ahb_bridge`

## Requirements
- R1: While `rst_ni` is low, `ahb_trans_o` is IDLE (2'b00) and `apb_ready_o` is 0.
- R2: A cycle with `apb_sel_i`=1 and `apb_en_i`=0 while the bridge is idle registers the request. In the next cycle `ahb_trans_o` is NONSEQ (2'b10), `ahb_write_o` equals the registered write flag and `ahb_addr_o` equals the registered address (subject to R4).
- R3: `ahb_burst_o` is 3'b000 (single) and `ahb_lock_o` is 0 on every transfer.
- R4: For an APB4 write, the strobe selects the size and the address offset bits [1:0]. 4'b1111 gives word (3'b010) at offset 0. 4'b0011 gives halfword (3'b001) at offset 0, and 4'b1100 gives halfword at offset 2. A strobe with one bit set at lane k gives byte (3'b000) at offset k. Any other strobe gives word at offset 0. Reads, and all transfers with APB4 disabled, use word size and pass the APB address unchanged.
- R5: `ahb_prot_o` is {2'b00, prot[0], ~prot[2]} in APB4 mode and 4'b0001 otherwise.
- R6: `apb_ready_o` stays 0 while the address phase is driven. A low `ahb_ready_i` during the address phase holds the address, size, write flag and protection stable and extends the APB transfer by one cycle per low cycle.
- R7: After the address phase is accepted, `ahb_trans_o` returns to IDLE, and `ahb_wdata_o` carries the registered write data through the data phase.
- R8: Without the response register, `apb_ready_o` follows `ahb_ready_i` in the data phase, `apb_err_o` reports `ahb_resp_i` at completion, and `apb_rdata_o` passes `ahb_rdata_i` through. The APB access phase therefore lasts 2 + address stalls + data wait cycles.
- R9: With the response register, the data captured on the last data-phase cycle (read data and error) is returned one cycle later, and the access phase lasts one cycle longer than in R8.
- R10: Exactly one address phase is issued per APB transfer. `ahb_trans_o` is IDLE whenever no transfer is pending, and an APB access phase that is held past completion does not start a new transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Shared clock for both buses |
| rst_ni | input | 1 | Asynchronous active-low reset |
| apb_sel_i | input | 1 | APB select |
| apb_en_i | input | 1 | APB enable (access phase) |
| apb_addr_i | input | ADDR_W | APB address |
| apb_write_i | input | 1 | APB write flag |
| apb_wdata_i | input | 32 | APB write data |
| apb_strb_i | input | 4 | APB4 byte strobes |
| apb_prot_i | input | 3 | APB4 protection |
| apb_ready_o | output | 1 | APB ready (wait states when low) |
| apb_rdata_o | output | 32 | APB read data |
| apb_err_o | output | 1 | APB completer error |
| ahb_addr_o | output | ADDR_W | AHB address |
| ahb_trans_o | output | 2 | AHB transfer type |
| ahb_write_o | output | 1 | AHB write flag |
| ahb_size_o | output | 3 | AHB transfer size |
| ahb_burst_o | output | 3 | AHB burst type |
| ahb_prot_o | output | 4 | AHB protection |
| ahb_lock_o | output | 1 | AHB locked transfer |
| ahb_wdata_o | output | 32 | AHB write data |
| ahb_rdata_i | input | 32 | AHB read data |
| ahb_ready_i | input | 1 | AHB ready |
| ahb_resp_i | input | 1 | AHB error response |

## Verification
Several rules are checked by the assertions on every cycle. A captured request always produces an address phase on the next cycle, and the address-phase attributes stay frozen while the responder stalls. The transfer type drops back to IDLE right after acceptance. Ready is never given during the address phase, and a completed handshake is never followed by ready or a new address phase. The registered option is also checked to answer exactly one cycle after the last data-phase cycle. The attribute mapping from strobe and protection codes, the returned read data and error, the exact stall-dependent latencies and the one-request-one-transfer count can only be shown by the bench. It sweeps every strobe and protection code across three build variants, with varied address stalls, data wait states and two-cycle error responses.

// File: rtl/apb_ahb_bridge_pkg.sv
package apb_ahb_bridge_pkg;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned LANES  = WORD_W / 8;
  localparam int unsigned OFS_W  = $clog2(LANES);

  typedef enum logic [1:0] {
    BR_IDLE,
    BR_ADDR,
    BR_DATA,
    BR_RESP
  } br_state_e;

  localparam logic [1:0] TRANS_IDLE   = 2'b00;
  localparam logic [1:0] TRANS_NONSEQ = 2'b10;
  localparam logic [2:0] SZ_BYTE      = 3'b000;
  localparam logic [2:0] SZ_HALF      = 3'b001;
  localparam logic [2:0] SZ_WORD      = 3'b010;
  localparam logic [2:0] BURST_SINGLE = 3'b000;
  localparam logic [3:0] PROT_PLAIN   = 4'b0001;

  function automatic logic [2:0] strb_size(input logic [LANES-1:0] strb);
    logic [2:0] sz;
    unique case (strb)
      4'b0011, 4'b1100:                   sz = SZ_HALF;
      4'b0001, 4'b0010, 4'b0100, 4'b1000: sz = SZ_BYTE;
      default:                            sz = SZ_WORD;
    endcase
    return sz;
  endfunction

  function automatic logic [OFS_W-1:0] strb_offset(input logic [LANES-1:0] strb);
    logic [OFS_W-1:0] ofs;
    unique case (strb)
      4'b0010:          ofs = 2'd1;
      4'b0100, 4'b1100: ofs = 2'd2;
      4'b1000:          ofs = 2'd3;
      default:          ofs = 2'd0;
    endcase
    return ofs;
  endfunction

  function automatic logic [3:0] prot_map(input logic [2:0] prot);
    return {2'b00, prot[0], ~prot[2]};
  endfunction

endpackage

// File: rtl/apb_ahb_req_reg.sv
module apb_ahb_req_reg
  import apb_ahb_bridge_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter bit          APB4   = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              write_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [LANES-1:0]  strb_i,
  input  logic [2:0]        prot_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              write_o,
  output logic [2:0]        size_o,
  output logic [3:0]        prot_o,
  output logic [WORD_W-1:0] wdata_o
);

  logic [ADDR_W-1:0] addr_d;
  logic [2:0]        size_d;
  logic [3:0]        prot_d;

  generate
    if (APB4) begin : g_apb4
      logic unused_prot;
      assign unused_prot = prot_i[1];
      always_comb begin
        addr_d = addr_i;
        size_d = SZ_WORD;
        if (write_i) begin
          addr_d = {addr_i[ADDR_W-1:OFS_W], strb_offset(strb_i)};
          size_d = strb_size(strb_i);
        end
        prot_d = prot_map(prot_i);
      end
    end else begin : g_apb3
      logic unused_apb4_in;
      assign unused_apb4_in = ^{strb_i, prot_i};
      always_comb begin
        addr_d = addr_i;
        size_d = SZ_WORD;
        prot_d = PROT_PLAIN;
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o  <= '0;
      write_o <= 1'b0;
      size_o  <= SZ_WORD;
      prot_o  <= PROT_PLAIN;
      wdata_o <= '0;
    end else if (load_i) begin
      addr_o  <= addr_d;
      write_o <= write_i;
      size_o  <= size_d;
      prot_o  <= prot_d;
      wdata_o <= wdata_i;
    end
  end

endmodule

// File: rtl/apb_ahb_ctrl.sv
module apb_ahb_ctrl
  import apb_ahb_bridge_pkg::*;
#(
  parameter bit REG_RESP = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_i,
  input  logic en_i,
  input  logic hready_i,
  output logic load_o,
  output logic addr_ph_o,
  output logic data_ph_o,
  output logic resp_ph_o
);

  br_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    load_o  = 1'b0;
    unique case (state_q)
      BR_IDLE: if (sel_i && !en_i) begin
        load_o  = 1'b1;
        state_d = BR_ADDR;
      end
      BR_ADDR: if (hready_i) state_d = BR_DATA;
      BR_DATA: if (hready_i) state_d = REG_RESP ? BR_RESP : BR_IDLE;
      BR_RESP: state_d = BR_IDLE;
      default: state_d = BR_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= BR_IDLE;
    else         state_q <= state_d;
  end

  assign addr_ph_o = (state_q == BR_ADDR);
  assign data_ph_o = (state_q == BR_DATA);
  assign resp_ph_o = (state_q == BR_RESP);

  // R2: a captured request launches the address phase next cycle
  p_launch_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> addr_ph_o);

  // R6: a stalled address phase is held
  p_addr_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_ph_o && !hready_i) |=> addr_ph_o);

  // R7: an accepted address phase moves to the data phase
  p_one_addr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_ph_o && hready_i) |=> (data_ph_o && !addr_ph_o));

endmodule

// File: rtl/apb_ahb_resp.sv
module apb_ahb_resp
  import apb_ahb_bridge_pkg::*;
#(
  parameter bit REG_RESP = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              data_ph_i,
  input  logic              resp_ph_i,
  input  logic              hready_i,
  input  logic              hresp_i,
  input  logic [WORD_W-1:0] hrdata_i,
  output logic              ready_o,
  output logic              err_o,
  output logic [WORD_W-1:0] rdata_o
);

  generate
    if (REG_RESP) begin : g_reg
      logic              err_q;
      logic [WORD_W-1:0] rdata_q;
      logic              cap_en;

      assign cap_en = data_ph_i && hready_i;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          err_q   <= 1'b0;
          rdata_q <= '0;
        end else if (cap_en) begin
          err_q   <= hresp_i;
          rdata_q <= hrdata_i;
        end
      end

      assign ready_o = resp_ph_i;
      assign err_o   = resp_ph_i && err_q;
      assign rdata_o = rdata_q;

      // R9: the registered answer arrives exactly one cycle after the data phase ends
      p_late_ready_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (data_ph_i && hready_i) |=> ready_o);

      // R9: an error on the last data-phase cycle is reported one cycle later
      p_late_err_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (data_ph_i && hready_i && hresp_i) |=> err_o);
    end else begin : g_comb
      logic unused_comb;
      assign unused_comb = ^{clk_i, rst_ni, resp_ph_i};
      assign ready_o = data_ph_i && hready_i;
      assign err_o   = data_ph_i && hready_i && hresp_i;
      assign rdata_o = hrdata_i;
    end
  endgenerate

endmodule

// File: rtl/apb_ahb_bridge.sv
module apb_ahb_bridge
  import apb_ahb_bridge_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter bit          APB4     = 1'b1,
  parameter bit          REG_RESP = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              apb_sel_i,
  input  logic              apb_en_i,
  input  logic [ADDR_W-1:0] apb_addr_i,
  input  logic              apb_write_i,
  input  logic [31:0]       apb_wdata_i,
  input  logic [3:0]        apb_strb_i,
  input  logic [2:0]        apb_prot_i,
  output logic              apb_ready_o,
  output logic [31:0]       apb_rdata_o,
  output logic              apb_err_o,
  output logic [ADDR_W-1:0] ahb_addr_o,
  output logic [1:0]        ahb_trans_o,
  output logic              ahb_write_o,
  output logic [2:0]        ahb_size_o,
  output logic [2:0]        ahb_burst_o,
  output logic [3:0]        ahb_prot_o,
  output logic              ahb_lock_o,
  output logic [31:0]       ahb_wdata_o,
  input  logic [31:0]       ahb_rdata_i,
  input  logic              ahb_ready_i,
  input  logic              ahb_resp_i
);

  logic load, addr_ph, data_ph, resp_ph;

  apb_ahb_ctrl #(.REG_RESP(REG_RESP)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sel_i     (apb_sel_i),
    .en_i      (apb_en_i),
    .hready_i  (ahb_ready_i),
    .load_o    (load),
    .addr_ph_o (addr_ph),
    .data_ph_o (data_ph),
    .resp_ph_o (resp_ph)
  );

  apb_ahb_req_reg #(.ADDR_W(ADDR_W), .APB4(APB4)) u_req (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .addr_i  (apb_addr_i),
    .write_i (apb_write_i),
    .wdata_i (apb_wdata_i),
    .strb_i  (apb_strb_i),
    .prot_i  (apb_prot_i),
    .addr_o  (ahb_addr_o),
    .write_o (ahb_write_o),
    .size_o  (ahb_size_o),
    .prot_o  (ahb_prot_o),
    .wdata_o (ahb_wdata_o)
  );

  apb_ahb_resp #(.REG_RESP(REG_RESP)) u_resp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .data_ph_i (data_ph),
    .resp_ph_i (resp_ph),
    .hready_i  (ahb_ready_i),
    .hresp_i   (ahb_resp_i),
    .hrdata_i  (ahb_rdata_i),
    .ready_o   (apb_ready_o),
    .err_o     (apb_err_o),
    .rdata_o   (apb_rdata_o)
  );

  assign ahb_trans_o = addr_ph ? TRANS_NONSEQ : TRANS_IDLE;
  assign ahb_burst_o = BURST_SINGLE;
  assign ahb_lock_o  = 1'b0;

  // R6: no ready towards APB while an address phase is on the bus
  p_no_ready_addr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ahb_trans_o == TRANS_NONSEQ) |-> !apb_ready_o);

  // R6: address-phase attributes frozen while the responder stalls
  p_stable_attr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ahb_trans_o == TRANS_NONSEQ && !ahb_ready_i) |=>
      ($stable(ahb_addr_o) && $stable(ahb_size_o) &&
       $stable(ahb_write_o) && $stable(ahb_prot_o)));

  // R10: a completed handshake is not followed by ready or a new address phase
  p_handoff_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (apb_ready_o && apb_sel_i && apb_en_i) |=>
      (ahb_trans_o == TRANS_IDLE && !apb_ready_o));

endmodule

// File: tb/ahb_resp_model.sv
module ahb_resp_model #(
  parameter int unsigned AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    htrans,
  input  logic [AW-1:0] haddr,
  input  logic          hwrite,
  input  logic [2:0]    hsize,
  input  logic [2:0]    hburst,
  input  logic [3:0]    hprot,
  input  logic          hlock,
  input  logic [31:0]   hwdata,
  input  int            wait_n,
  input  logic          err,
  input  int            stall_n,
  output logic          hready,
  output logic          hresp,
  output logic [31:0]   hrdata,
  output logic [AW-1:0] rec_addr,
  output logic          rec_write,
  output logic [2:0]    rec_size,
  output logic [2:0]    rec_burst,
  output logic [3:0]    rec_prot,
  output logic          rec_lock,
  output logic [31:0]   rec_wdata,
  output int            accepts,
  output int            bad
);

  typedef enum logic [1:0] {M_IDLE, M_WAIT, M_ERR, M_LAST} m_e;
  m_e st;
  int wcnt, scnt;

  function automatic logic [31:0] pat(input logic [AW-1:0] a);
    return 32'(a) * 32'h0001_0003 + 32'h1357_9BDF;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= M_IDLE; hready <= 1'b1; hresp <= 1'b0; hrdata <= '0;
      accepts <= 0; bad <= 0; scnt <= 0; wcnt <= 0;
      rec_addr <= '0; rec_write <= 1'b0; rec_size <= '0; rec_burst <= '0;
      rec_prot <= '0; rec_lock <= 1'b0; rec_wdata <= '0;
    end else begin
      case (st)
        M_IDLE: begin
          if (htrans == 2'b10) begin
            if (hready) begin
              accepts <= accepts + 1; scnt <= 0;
              rec_addr <= haddr; rec_write <= hwrite; rec_size <= hsize;
              rec_burst <= hburst; rec_prot <= hprot; rec_lock <= hlock;
              hrdata <= ~pat(haddr);
              if (wait_n != 0) begin
                st <= M_WAIT; wcnt <= wait_n; hready <= 1'b0;
              end else if (err) begin
                st <= M_ERR; hready <= 1'b0; hresp <= 1'b1;
              end else begin
                st <= M_LAST; hready <= 1'b1; hrdata <= pat(haddr);
              end
            end else begin
              scnt <= scnt + 1;
              if (scnt + 1 >= stall_n) hready <= 1'b1;
            end
          end else begin
            hready <= (stall_n == 0);
          end
        end
        M_WAIT: begin
          if (htrans != 2'b00) bad <= bad + 1;
          if (wcnt > 1) wcnt <= wcnt - 1;
          else if (err) begin
            st <= M_ERR; hresp <= 1'b1;
          end else begin
            st <= M_LAST; hready <= 1'b1; hrdata <= pat(rec_addr);
          end
        end
        M_ERR: begin
          if (htrans != 2'b00) bad <= bad + 1;
          st <= M_LAST; hready <= 1'b1; hrdata <= pat(rec_addr);
        end
        default: begin
          if (htrans != 2'b00) bad <= bad + 1;
          rec_wdata <= hwdata;
          st <= M_IDLE; hresp <= 1'b0; hrdata <= '0;
          hready <= (stall_n == 0);
        end
      endcase
    end
  end

endmodule

// File: tb/apb_ahb_bridge_tb.sv
module apb_ahb_bridge_tb;

  localparam int NCFG = 3;
  localparam int AW   = 16;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n;
  logic          psel, penable, pwrite;
  logic [AW-1:0] paddr;
  logic [31:0]   pwdata;
  logic [3:0]    pstrb;
  logic [2:0]    pprot;
  int            k_wait, k_stall;
  logic          k_err;

  logic [NCFG-1:0] pready, pslverr, hwrite, hlock, hready, hresp;
  logic [31:0]     prdata [NCFG];
  logic [AW-1:0]   haddr  [NCFG];
  logic [1:0]      htrans [NCFG];
  logic [2:0]      hsize  [NCFG];
  logic [2:0]      hburst [NCFG];
  logic [3:0]      hprot  [NCFG];
  logic [31:0]     hwdata [NCFG];
  logic [31:0]     hrdata [NCFG];
  logic [AW-1:0]   r_addr [NCFG];
  logic [NCFG-1:0] r_write, r_lock;
  logic [2:0]      r_size [NCFG];
  logic [2:0]      r_burst[NCFG];
  logic [3:0]      r_prot [NCFG];
  logic [31:0]     r_wdata[NCFG];
  int              accepts[NCFG];
  int              bad    [NCFG];

  int n_chk = 0;
  int n_fail = 0;

  for (genvar g = 0; g < NCFG; g++) begin : g_cfg
    localparam bit CFG_APB4 = (g != 2);
    localparam bit CFG_REG  = (g != 0);

    apb_ahb_bridge #(.ADDR_W(AW), .APB4(CFG_APB4), .REG_RESP(CFG_REG)) u_dut (
      .clk_i(clk), .rst_ni(rst_n),
      .apb_sel_i(psel), .apb_en_i(penable), .apb_addr_i(paddr),
      .apb_write_i(pwrite), .apb_wdata_i(pwdata), .apb_strb_i(pstrb),
      .apb_prot_i(pprot), .apb_ready_o(pready[g]), .apb_rdata_o(prdata[g]),
      .apb_err_o(pslverr[g]), .ahb_addr_o(haddr[g]), .ahb_trans_o(htrans[g]),
      .ahb_write_o(hwrite[g]), .ahb_size_o(hsize[g]), .ahb_burst_o(hburst[g]),
      .ahb_prot_o(hprot[g]), .ahb_lock_o(hlock[g]), .ahb_wdata_o(hwdata[g]),
      .ahb_rdata_i(hrdata[g]), .ahb_ready_i(hready[g]), .ahb_resp_i(hresp[g])
    );

    ahb_resp_model #(.AW(AW)) u_slv (
      .clk(clk), .rst_n(rst_n), .htrans(htrans[g]), .haddr(haddr[g]),
      .hwrite(hwrite[g]), .hsize(hsize[g]), .hburst(hburst[g]), .hprot(hprot[g]),
      .hlock(hlock[g]), .hwdata(hwdata[g]), .wait_n(k_wait), .err(k_err),
      .stall_n(k_stall), .hready(hready[g]), .hresp(hresp[g]), .hrdata(hrdata[g]),
      .rec_addr(r_addr[g]), .rec_write(r_write[g]), .rec_size(r_size[g]),
      .rec_burst(r_burst[g]), .rec_prot(r_prot[g]), .rec_lock(r_lock[g]),
      .rec_wdata(r_wdata[g]), .accepts(accepts[g]), .bad(bad[g])
    );
  end

  function automatic bit cfg_apb4(input int g); return g != 2; endfunction
  function automatic int cfg_reg(input int g);  return (g != 0) ? 1 : 0; endfunction

  function automatic logic [31:0] pat(input logic [AW-1:0] a);
    return 32'(a) * 32'h0001_0003 + 32'h1357_9BDF;
  endfunction

  function automatic logic [2:0] e_size(input logic [3:0] s, input logic w, input bit apb4);
    int c = $countones(s);
    if (!apb4 || !w) return 3'd2;
    if (s == 4'b0011 || s == 4'b1100) return 3'd1;
    if (c == 1) return 3'd0;
    return 3'd2;
  endfunction

  function automatic logic [AW-1:0] e_addr(input logic [AW-1:0] a, input logic [3:0] s,
                                           input logic w, input bit apb4);
    int c = $countones(s);
    logic [1:0] ofs = 2'd0;
    if (!apb4 || !w) return a;
    if (c == 1) ofs = 2'($clog2(s));
    else if (s == 4'b1100) ofs = 2'd2;
    return {a[AW-1:2], ofs};
  endfunction

  function automatic logic [3:0] e_prot(input logic [2:0] p, input bit apb4);
    return apb4 ? {2'b00, p[0], ~p[2]} : 4'b0001;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic xfer(input logic [AW-1:0] a, input logic w, input logic [31:0] d,
                      input logic [3:0] s, input logic [2:0] p,
                      input int wt, input logic e, input int st);
    int lat[NCFG];
    logic [31:0] rd[NCFG];
    logic er[NCFG];
    int acc0[NCFG];
    logic [NCFG-1:0] done;
    int k;
    for (int g = 0; g < NCFG; g++) acc0[g] = accepts[g];
    @(negedge clk);
    k_wait = wt; k_err = e; k_stall = st;
    psel = 1'b1; penable = 1'b0; paddr = a; pwrite = w;
    pwdata = d; pstrb = s; pprot = p;
    @(negedge clk);
    penable = 1'b1; done = '0; k = 0;
    for (int g = 0; g < NCFG; g++) begin lat[g] = -1; rd[g] = '0; er[g] = 1'b0; end
    forever begin
      #1; k++;
      for (int g = 0; g < NCFG; g++)
        if (!done[g] && pready[g]) begin
          done[g] = 1'b1; lat[g] = k; rd[g] = prdata[g]; er[g] = pslverr[g];
        end
      if (done == '1 || k >= 40) break;
      @(negedge clk);
    end
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
    for (int g = 0; g < NCFG; g++) begin
      bit a4 = cfg_apb4(g);
      chk(cfg_reg(g) ? "R9" : "R8", "access cycles (R6 stalls)", 32'(lat[g]),
          32'(2 + st + wt + int'(e) + cfg_reg(g)));
      chk("R10", "one address phase per transfer", 32'(accepts[g] - acc0[g]), 32'd1);
      chk("R2", "address", 32'(r_addr[g]), 32'(e_addr(a, s, w, a4)));
      chk("R2", "write flag", 32'(r_write[g]), 32'(w));
      chk("R4", "size", 32'(r_size[g]), 32'(e_size(s, w, a4)));
      chk("R5", "protection", 32'(r_prot[g]), 32'(e_prot(p, a4)));
      chk("R3", "burst and lock", {28'd0, r_burst[g], r_lock[g]}, 32'd0);
      chk(cfg_reg(g) ? "R9" : "R8", "error", 32'(er[g]), 32'(e));
      if (w) chk("R7", "write data", r_wdata[g], d);
      else   chk(cfg_reg(g) ? "R9" : "R8", "read data", rd[g], pat(a));
    end
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    rst_n = 1'b0; psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    paddr = '0; pwdata = '0; pstrb = '0; pprot = '0;
    k_wait = 0; k_err = 1'b0; k_stall = 0;
    repeat (3) @(negedge clk);
    // R1: reset state, with a setup request present that must be ignored
    psel = 1'b1;
    @(negedge clk);
    for (int g = 0; g < NCFG; g++) begin
      chk("R1", "trans in reset", 32'(htrans[g]), 32'd0);
      chk("R1", "ready in reset", 32'(pready[g]), 32'd0);
    end
    psel = 1'b0;
    rst_n = 1'b1;
    repeat (3) begin
      @(negedge clk);
      for (int g = 0; g < NCFG; g++)
        chk("R10", "idle trans with no request", 32'(htrans[g]), 32'd0);
    end
    // R4 R5 R7: every strobe and protection code on writes
    for (int s = 0; s < 16; s++)
      xfer(AW'(16'h0200 + s * 16 + (s % 4)), 1'b1, 32'hA5000000 + 32'(s * 32'h01010101),
           4'(s), 3'(s % 8), s % 3, (s % 5) == 4, (s % 4 == 3) ? 2 : (s % 4 == 1 ? 1 : 0));
    // R8 R9: reads with waits, stalls and errors; strobes must not matter
    for (int i = 0; i < 8; i++)
      xfer(AW'(16'h4000 + i * 36 + (i % 4)), 1'b0, 32'hFFFF_FFFF, 4'(i * 2 + 1),
           3'(7 - i), i % 3, (i % 3) == 1, i % 2);
    // R7 R10: bus idle afterwards, no address phase seen during a data phase
    repeat (3) begin
      @(negedge clk);
      for (int g = 0; g < NCFG; g++)
        chk("R10", "idle trans after traffic", 32'(htrans[g]), 32'd0);
    end
    for (int g = 0; g < NCFG; g++)
      chk("R7", "address phase during data phase", 32'(bad[g]), 32'd0);
    report();
    $finish;
  end

endmodule